// File: doc/BRIEF.md
# Fixed-Point Requantizer

This stage takes a fixed-point sample in one Q format and produces the same value in a different Q format, registered once. The input format has `IN_INT` integer bits and `IN_FRAC` fraction bits. The output format has `OUT_INT` integer bits and `OUT_FRAC` fraction bits. In both formats the integer count includes the sign bit when `SIGNED` is set. The binary points exist only in these parameters, so the stage always knows which input bits fall below the new least significant bit.

When the output has fewer fraction bits, the discarded bits are resolved by one of four rounding rules, chosen per sample on a 2-bit mode input. When the output has more fraction bits, zeros are appended below the old LSB. The integer field is sign- or zero-extended when it grows. When the rounded value no longer fits the output range, it is clamped to the nearest rail and an overflow flag is raised for that sample. A valid bit travels alongside the data with one clock of latency.

Top module: `fxp_requant`

## Requirements
- R1: Mode 2'b00 (floor) drops every input bit below the output LSB and never adds an increment.
- R2: Mode 2'b01 (ceiling) adds one output LSB to the truncated value whenever any dropped bit is 1.
- R3: Mode 2'b10 (half-up) adds one output LSB when the highest dropped bit is 1.
- R4: Mode 2'b11 (half-even) rounds like half-up, except on an exact tie. A tie means the highest dropped bit is 1 and all lower dropped bits are 0. On a tie it adds one only when the truncated result's LSB is 1, so the result is always even.
- R5: With `SIGNED` set, the rules act on the two's-complement pattern. As a result, floor rounds negative values toward minus infinity and ceiling rounds them toward plus infinity.
- R6: When `OUT_INT` exceeds `IN_INT`, the integer field is sign-extended for signed data and zero-extended for unsigned data.
- R7: When `OUT_FRAC` is at least `IN_FRAC`, zero bits fill the new low positions and the mode has no effect on the result.
- R8: A result outside the output range is clamped. Signed data clamps to the largest positive or most negative code. Unsigned data clamps to all ones. `out_ovf` is 1 for exactly that sample and implies `out_valid`.
- R9: `out_valid` equals `in_valid` from the previous clock. `out_data` and `out_ovf` belong to that sample. `out_data` holds its value when `in_valid` was 0.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_ovf` and `out_data` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is present this cycle |
| in_data | input | IN_INT+IN_FRAC | Input value, format Q`IN_INT`.`IN_FRAC` |
| in_mode | input | 2 | Rounding rule: 00 floor, 01 ceiling, 10 half-up, 11 half-even |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | OUT_INT+OUT_FRAC | Result, format Q`OUT_INT`.`OUT_FRAC` |
| out_ovf | output | 1 | The current result was clamped |

## Verification
Each result, its overflow flag and its valid bit are due on the first rising edge after the sample is presented. No other stage lies in between. The bench changes inputs on the falling edge and lets exactly one rising edge pass. It then compares outputs on the following falling edge against values computed with integer floor division and explicit tie handling. The hold and reset behaviour are checked in the cycle right after an idle input and right after reset is released. This shows that nothing arrives a cycle early or late.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [1:0] {
        RND_FLOOR     = 2'b00,
        RND_CEIL      = 2'b01,
        RND_HALF_UP   = 2'b10,
        RND_HALF_EVEN = 2'b11
    } rnd_mode_e;

    // Summary of the bits that fall below the new LSB
    typedef struct packed {
        logic half;    // highest dropped bit
        logic sticky;  // OR of the dropped bits under it
        logic lsb;     // lowest kept bit
    } rnd_bits_t;

    function automatic int fxp_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic needs_inc(input rnd_mode_e mode, input rnd_bits_t rb);
        logic inc;
        case (mode)
            RND_FLOOR:     inc = 1'b0;
            RND_CEIL:      inc = rb.half | rb.sticky;
            RND_HALF_UP:   inc = rb.half;
            RND_HALF_EVEN: inc = rb.half & (rb.sticky | rb.lsb);
            default:       inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fxp_align.sv
module fxp_align
    import fxp_pkg::*;
#(
    parameter int IN_INT   = 4,
    parameter int IN_FRAC  = 4,
    parameter int OUT_FRAC = 2,
    localparam int IN_W    = IN_INT + IN_FRAC,
    localparam int KW      = IN_INT + OUT_FRAC
) (
    input  logic [IN_W-1:0] din,
    output logic [KW-1:0]   kept,
    output rnd_bits_t       rb
);

    generate
        if (IN_FRAC > OUT_FRAC) begin : g_narrow
            localparam int DROP = IN_FRAC - OUT_FRAC;
            assign kept      = din[IN_W-1:DROP];
            assign rb.half   = din[DROP-1];
            assign rb.lsb    = din[DROP];
            if (DROP > 1) begin : g_sticky
                assign rb.sticky = |din[DROP-2:0];
            end else begin : g_nosticky
                assign rb.sticky = 1'b0;
            end
        end else begin : g_widen
            localparam int PAD = OUT_FRAC - IN_FRAC;
            if (PAD > 0) begin : g_pad
                assign kept = {din, {PAD{1'b0}}};
            end else begin : g_same
                assign kept = din;
            end
            assign rb = '0;
        end
    endgenerate

endmodule

// File: rtl/fxp_incr.sv
module fxp_incr
    import fxp_pkg::*;
#(
    parameter int KW     = 6,
    parameter int SW     = 7,
    parameter bit SIGNED = 1'b1
) (
    input  logic [KW-1:0] kept,
    input  rnd_mode_e     mode,
    input  rnd_bits_t     rb,
    output logic [SW-1:0] sum
);

    logic [SW-1:0] ext;
    logic          inc;

    generate
        if (SIGNED) begin : g_sext
            assign ext = {{(SW-KW){kept[KW-1]}}, kept};
        end else begin : g_zext
            assign ext = {{(SW-KW){1'b0}}, kept};
        end
    endgenerate

    assign inc = needs_inc(mode, rb);
    assign sum = ext + {{(SW-1){1'b0}}, inc};

endmodule

// File: rtl/fxp_sat.sv
module fxp_sat #(
    parameter int SW     = 7,
    parameter int OUT_W  = 5,
    parameter bit SIGNED = 1'b1
) (
    input  logic [SW-1:0]    sum,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);

    localparam logic [OUT_W-1:0] HI = {OUT_W{1'b1}} >> (SIGNED ? 1 : 0);
    localparam logic [OUT_W-1:0] LO = ~HI & {OUT_W{SIGNED}};

    logic fits;

    generate
        if (SIGNED) begin : g_s
            assign fits = (&sum[SW-1:OUT_W-1]) | ~(|sum[SW-1:OUT_W-1]);
            assign dout = fits ? sum[OUT_W-1:0] : (sum[SW-1] ? LO : HI);
        end else begin : g_u
            assign fits = ~(|sum[SW-1:OUT_W]);
            assign dout = fits ? sum[OUT_W-1:0] : HI;
        end
    endgenerate

    assign ovf = ~fits;

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
    import fxp_pkg::*;
#(
    parameter int IN_INT   = 4,
    parameter int IN_FRAC  = 4,
    parameter int OUT_INT  = 3,
    parameter int OUT_FRAC = 2,
    parameter bit SIGNED   = 1'b1,
    localparam int IN_W    = IN_INT + IN_FRAC,
    localparam int OUT_W   = OUT_INT + OUT_FRAC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [1:0]       in_mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_ovf
);

    localparam int KW = IN_INT + OUT_FRAC;
    localparam int SW = fxp_max(IN_INT, OUT_INT) + OUT_FRAC + 1;

    logic [KW-1:0]    kept;
    rnd_bits_t        rb;
    logic [SW-1:0]    sum;
    logic [OUT_W-1:0] clamped;
    logic             ovf_c;

    fxp_align #(
        .IN_INT  (IN_INT),
        .IN_FRAC (IN_FRAC),
        .OUT_FRAC(OUT_FRAC)
    ) u_align (
        .din (in_data),
        .kept(kept),
        .rb  (rb)
    );

    fxp_incr #(
        .KW    (KW),
        .SW    (SW),
        .SIGNED(SIGNED)
    ) u_incr (
        .kept(kept),
        .mode(rnd_mode_e'(in_mode)),
        .rb  (rb),
        .sum (sum)
    );

    fxp_sat #(
        .SW    (SW),
        .OUT_W (OUT_W),
        .SIGNED(SIGNED)
    ) u_sat (
        .sum (sum),
        .dout(clamped),
        .ovf (ovf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ovf   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_ovf   <= in_valid & ovf_c;
            if (in_valid) begin
                out_data <= clamped;
            end
        end
    end

endmodule

// File: rtl/fxp_requant_chk.sv
module fxp_requant_chk #(
    parameter int OUT_W  = 5,
    parameter bit SIGNED = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             out_ovf
);

    localparam logic [OUT_W-1:0] RAIL_HI = {OUT_W{1'b1}} >> (SIGNED ? 1 : 0);
    localparam logic [OUT_W-1:0] RAIL_LO = ~RAIL_HI & {OUT_W{SIGNED}};

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_ovf && out_data == '0));

    // R8
    ovf_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_valid);

    // R8
    ovf_rail_chk: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_data == RAIL_HI || out_data == RAIL_LO));

endmodule

bind fxp_requant fxp_requant_chk #(
    .OUT_W (OUT_INT + OUT_FRAC),
    .SIGNED(SIGNED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ovf  (out_ovf)
);

// File: tb/test_fxp_requant.sv
`timescale 1ns/1ps
module test_fxp_requant;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_mode = 2'b00;
    logic [7:0] a_in = '0;
    logic [2:0] b_in = '0;
    logic [4:0] a_out;
    logic [6:0] b_out, c_out;
    logic       a_v, b_v, c_v, a_ovf, b_ovf, c_ovf;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    // signed Q4.4 -> Q3.2 (narrowing both fields)
    fxp_requant #(.IN_INT(4), .IN_FRAC(4), .OUT_INT(3), .OUT_FRAC(2), .SIGNED(1'b1)) i_fxp_requant (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(a_in), .in_mode(in_mode),
        .out_valid(a_v), .out_data(a_out), .out_ovf(a_ovf));

    // unsigned Q2.1 -> Q4.3 (widening both fields)
    fxp_requant #(.IN_INT(2), .IN_FRAC(1), .OUT_INT(4), .OUT_FRAC(3), .SIGNED(1'b0)) i_fxp_requant_u (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(b_in), .in_mode(in_mode),
        .out_valid(b_v), .out_data(b_out), .out_ovf(b_ovf));

    // signed Q2.1 -> Q4.3 (widening both fields)
    fxp_requant #(.IN_INT(2), .IN_FRAC(1), .OUT_INT(4), .OUT_FRAC(3), .SIGNED(1'b1)) i_fxp_requant_s (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(b_in), .in_mode(in_mode),
        .out_valid(c_v), .out_data(c_out), .out_ovf(c_ovf));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Rounds v / 2**d by the chosen rule using integer arithmetic.
    function automatic int round_div(input int v, input int mode, input int d);
        int div, fl, rem;
        div = 1 << d;
        fl  = (v >= 0) ? (v / div) : -((-v + div - 1) / div);
        rem = v - fl * div;
        case (mode)
            0: return fl;
            1: return fl + ((rem != 0) ? 1 : 0);
            2: return fl + ((rem >= div / 2) ? 1 : 0);
            default: begin
                if (rem > div / 2) return fl + 1;
                if (rem == div / 2) return fl + (fl & 1);
                return fl;
            end
        endcase
    endfunction

    initial begin
        int          va, ea, ca;
        bit          ov;
        string       tag;
        logic [4:0]  last_a;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: registers cleared after reset
        check(a_v == 1'b0 && b_v == 1'b0 && c_v == 1'b0, "R10 valid", a_v, 0);
        check(a_ovf == 1'b0, "R10 ovf", a_ovf, 0);
        check(a_out == 5'd0, "R10 data", a_out, 0);

        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 256; p++) begin
                in_valid = 1'b1;
                in_mode  = m[1:0];
                a_in     = p[7:0];
                b_in     = p[2:0];
                @(posedge clk);
                @(negedge clk);

                va = int'($signed(a_in));
                ea = round_div(va, m, 2);
                ov = (ea > 15) || (ea < -16);
                ca = (ea > 15) ? 15 : ((ea < -16) ? -16 : ea);
                if (ov) tag = "R8";
                else if (va < 0 && m < 2) tag = "R5";
                else if (m == 0) tag = "R1";
                else if (m == 1) tag = "R2";
                else if (m == 2) tag = "R3";
                else tag = "R4";
                check(a_out == ca[4:0], tag, int'($signed(a_out)), ca);
                // R8: flag marks clamped samples only
                check(a_ovf == ov, "R8 flag", a_ovf, ov);
                // R9: valid one cycle after input
                check(a_v && b_v && c_v, "R9 valid", a_v, 1);

                if (p < 8) begin
                    // unsigned widening: zero extension (R6) and zero fill (R7)
                    check(b_out == 7'(b_in) << 2, b_in[2] ? "R6 zext" : "R7 unsigned",
                          b_out, int'(b_in) << 2);
                    // signed widening: sign extension (R6) and zero fill (R7)
                    check(c_out == 7'(int'($signed(b_in)) * 4), b_in[2] ? "R6 sext" : "R7 signed",
                          int'($signed(c_out)), int'($signed(b_in)) * 4);
                    check(!b_ovf && !c_ovf, "R7 no ovf", b_ovf | c_ovf, 0);
                end
            end
        end

        // R9: idle input drops valid and holds data
        last_a   = a_out;
        in_valid = 1'b0;
        a_in     = 8'h5a;
        @(posedge clk);
        @(negedge clk);
        check(!a_v && !b_v && !c_v, "R9 idle valid", a_v, 0);
        check(a_out == last_a, "R9 hold", a_out, last_a);
        check(!a_ovf, "R9 idle ovf", a_ovf, 0);

        // R10: reset in the middle of traffic (overflowing sample first)
        in_valid = 1'b1;
        in_mode  = 2'b01;
        a_in     = 8'h7f;
        @(posedge clk);
        @(negedge clk);
        check(a_ovf && a_out == 5'd15, "R8 pos rail", a_out, 15);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!a_v && !a_ovf && a_out == 5'd0, "R10 midstream", a_out, 0);
        rst      = 1'b0;
        in_valid = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule